// File: doc/BRIEF.md
# Indexed Gamma Palette with Auto-Increment

This block holds one display pipe's colour lookup table. It has 1024 entries, and each entry packs three 10-bit channels. Software loads the table through two write registers. A write to the pointer register sets the entry address, turns auto-advance on or off, and sets a half-confined wrap flag. Each write to the entry register stores one packed entry at the current address. When auto-advance is on, that write also moves the address on by one.

A control register selects how the table is used:
- **Pass-through:** the pixel is not looked up.
- **Full-table lookup:** the 10-bit pixel channel indexes all 1024 entries directly.
- **Split lookup:** the low 512 entries form a linearising (degamma) table and the high 512 entries form a gamma table. The caller picks the half with a select input, so one table can serve both ends of a degamma → matrix → gamma chain.

Each looked-up 10-bit value is widened to a 17-bit fixed-point result in which 1.0 is 1<<16. The result is then limited by a per-channel ceiling register. Results appear one clock after the request.

Top module: `gp_palette_top`

## Requirements
- R1: After reset the following hold:
  - `out_valid` is 0 and all results are 0.
  - The control register is 0, which selects pass-through.
  - The write address is 0 with auto-advance off.
  - Every channel ceiling is 0x10000.
- R2: A pointer-register write loads the write address from bits 9:0, auto-advance from bit 15 and the half-confined wrap flag from bit 31. If a pointer write and an entry write arrive in the same cycle, the entry write uses the old address and the pointer write decides the new one.
- R3: An entry-register write stores the red channel from bits 29:20, green from bits 19:10 and blue from bits 9:0 at the current write address.
- R4: With auto-advance on, each entry write moves the address up by one. With it off, the address stays put, so repeated writes overwrite the same entry.
- R5: Without the wrap flag, auto-advance wraps from 1023 to 0. With the wrap flag, the address keeps its bit 9: it wraps from 511 to 0 and from 1023 to 512.
- R6: The mode comes from control bits 1:0 only, and all other bits except 31 and 30 are ignored. The encodings are:
  - 0: pass-through.
  - 1 (10-bit) and 2 (12-bit): full-table lookup, with the entry index equal to the input channel.
  - 3: split lookup.
- R7: When control bits 31 and 30 (early and late gamma enable) are both 0, every mode behaves as pass-through.
- R8: In split mode the entry index is {in_half, channel[9:1]}: `in_half`=0 selects entries 0–511 and `in_half`=1 selects entries 512–1023.
- R9: Each channel's result is {1'b0, value, 6'b0}, where value is the looked-up or passed-through 10 bits. The result is limited to that channel's ceiling. The ceiling is written through `max_wr` with `max_sel` 0=red, 1=green, 2=blue; `max_sel`=3 writes nothing.
- R10: The results for a request with `in_valid` high appear on the next clock with `out_valid` high. A clock without `in_valid` gives `out_valid` low and leaves the results unchanged.
- R11: A lookup that reads an entry in the same cycle that entry is written returns the entry's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Pointer-register write strobe |
| idx_wdata | input | 32 | Pointer-register value (bit 31 wrap flag, bit 15 auto-advance, bits 9:0 address) |
| dat_wr | input | 1 | Entry-register write strobe |
| dat_wdata | input | 32 | Packed entry (bits 29:20 red, 19:10 green, 9:0 blue) |
| mode_wr | input | 1 | Control-register write strobe |
| mode_wdata | input | 32 | Control value (bit 31/30 enables, bits 1:0 mode) |
| max_wr | input | 1 | Ceiling write strobe |
| max_sel | input | 2 | Ceiling channel select |
| max_wdata | input | 17 | Ceiling value, 1.0 = 0x10000 |
| in_valid | input | 1 | Lookup request valid |
| in_half | input | 1 | Split-mode half select (0 degamma, 1 gamma) |
| in_r | input | 10 | Red input channel |
| in_g | input | 10 | Green input channel |
| in_b | input | 10 | Blue input channel |
| out_valid | output | 1 | Result valid |
| out_r | output | 17 | Red result |
| out_g | output | 17 | Green result |
| out_b | output | 17 | Blue result |

## Verification
A write address that has drifted is not visible by itself. It shows up on the first lookup of an entry that was loaded after the drift, which returns a value the bench does not expect; that mismatch appears one clock after the lookup request. A wrongly latched mode or enable bit shows on the very next result, as a pass-through value where a table value was expected or the reverse. A wrong ceiling shows on the next result whose value exceeds the ceiling. Wrap faults are targeted by writing two entries across each wrap point and reading both back.

// File: rtl/gp_pkg.sv
package gp_pkg;
    localparam int GP_CH_W  = 10;
    localparam int GP_NCH   = 3;
    localparam int GP_OUT_W = 17;

    typedef enum logic [1:0] {
        GM_PASS8  = 2'd0,
        GM_FULL10 = 2'd1,
        GM_FULL12 = 2'd2,
        GM_SPLIT  = 2'd3
    } gp_mode_e;
endpackage

// File: rtl/gp_index_ctrl.sv
module gp_index_ctrl #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [AW-1:0] idx_addr,
    input  logic          idx_ai,
    input  logic          idx_split,
    input  logic          dat_wr,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] ONE_FULL = 1;
    localparam logic [AW-2:0] ONE_HALF = 1;

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          ai;
        logic          split;
    } ictl_t;

    ictl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (dat_wr && s_q.ai) begin
            if (s_q.split)
                s_d.ptr = {s_q.ptr[AW-1], s_q.ptr[AW-2:0] + ONE_HALF};
            else
                s_d.ptr = s_q.ptr + ONE_FULL;
        end
        if (idx_wr) begin
            s_d.ptr   = idx_addr;
            s_d.ai    = idx_ai;
            s_d.split = idx_split;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr = s_q.ptr;

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> ptr == $past(idx_addr));

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !idx_wr && !s_q.ai) |=> $stable(ptr));

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !idx_wr && s_q.ai && !s_q.split) |=> ptr == $past(ptr) + ONE_FULL);

    assert_half_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !idx_wr && s_q.ai && s_q.split) |=> ptr[AW-1] == $past(ptr[AW-1]));
endmodule

// File: rtl/gp_lut_mem.sv
module gp_lut_mem #(
    parameter int AW  = 10,
    parameter int EW  = 30,
    parameter int NRD = 3
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [EW-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][EW-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata[i] = mem[raddr[i]];
    end
endmodule

// File: rtl/gp_chan_path.sv
module gp_chan_path #(
    parameter int CW = 10,
    parameter int OW = 17
) (
    input  logic          active,
    input  logic          split,
    input  logic          half,
    input  logic [CW-1:0] in_val,
    input  logic [CW-1:0] entry_fld,
    input  logic [OW-1:0] max_val,
    output logic [CW-1:0] addr,
    output logic [OW-1:0] res
);
    localparam int PAD = OW - CW - 1;

    logic [CW-1:0] sel;
    logic [OW-1:0] scaled;

    always_comb begin
        addr   = split ? {half, in_val[CW-1:1]} : in_val;
        sel    = active ? entry_fld : in_val;
        scaled = {1'b0, sel, {PAD{1'b0}}};
        res    = (scaled > max_val) ? max_val : scaled;
    end
endmodule

// File: rtl/gp_palette_top.sv
module gp_palette_top
    import gp_pkg::*;
#(
    parameter int CW  = GP_CH_W,
    parameter int NCH = GP_NCH,
    parameter int OW  = GP_OUT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [31:0]   idx_wdata,
    input  logic          dat_wr,
    input  logic [31:0]   dat_wdata,
    input  logic          mode_wr,
    input  logic [31:0]   mode_wdata,
    input  logic          max_wr,
    input  logic [1:0]    max_sel,
    input  logic [OW-1:0] max_wdata,
    input  logic          in_valid,
    input  logic          in_half,
    input  logic [CW-1:0] in_r,
    input  logic [CW-1:0] in_g,
    input  logic [CW-1:0] in_b,
    output logic          out_valid,
    output logic [OW-1:0] out_r,
    output logic [OW-1:0] out_g,
    output logic [OW-1:0] out_b
);
    localparam int            AW     = CW;
    localparam int            EW     = NCH * CW;
    localparam logic [OW-1:0] ONE_PT = 1 << (OW - 1);

    typedef struct packed {
        gp_mode_e                mode;
        logic                    pre_en;
        logic                    post_en;
        logic [NCH-1:0][OW-1:0]  maxv;
        logic                    vld;
        logic [NCH-1:0][OW-1:0]  res;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [AW-1:0]           wptr;
    logic [NCH-1:0][AW-1:0]  raddr;
    logic [NCH-1:0][EW-1:0]  rdata;
    logic [NCH-1:0][CW-1:0]  chan_in;
    logic [NCH-1:0][OW-1:0]  res_w;
    logic                    active;
    logic                    split;

    logic unused_bits;
    assign unused_bits = ^{idx_wdata[30:16], idx_wdata[14:10], dat_wdata[31:30], mode_wdata[29:2]};

    assign active  = (s_q.pre_en || s_q.post_en) && (s_q.mode != GM_PASS8);
    assign split   = (s_q.mode == GM_SPLIT);
    assign chan_in = {in_b, in_g, in_r};

    gp_index_ctrl #(.AW(AW)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .idx_addr  (idx_wdata[AW-1:0]),
        .idx_ai    (idx_wdata[15]),
        .idx_split (idx_wdata[31]),
        .dat_wr    (dat_wr),
        .ptr       (wptr)
    );

    gp_lut_mem #(.AW(AW), .EW(EW), .NRD(NCH)) u_mem (
        .clk   (clk),
        .we    (dat_wr),
        .waddr (wptr),
        .wdata (dat_wdata[EW-1:0]),
        .raddr (raddr),
        .rdata (rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gp_chan_path #(.CW(CW), .OW(OW)) u_ch (
            .active    (active),
            .split     (split),
            .half      (in_half),
            .in_val    (chan_in[i]),
            .entry_fld (rdata[i][(NCH-1-i)*CW +: CW]),
            .max_val   (s_q.maxv[i]),
            .addr      (raddr[i]),
            .res       (res_w[i])
        );

        assert_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> s_q.res[i] <= $past(s_q.maxv[i]));
    end

    always_comb begin
        s_d = s_q;
        if (mode_wr) begin
            s_d.mode    = gp_mode_e'(mode_wdata[1:0]);
            s_d.pre_en  = mode_wdata[31];
            s_d.post_en = mode_wdata[30];
        end
        if (max_wr && (32'(max_sel) < NCH))
            s_d.maxv[max_sel] = max_wdata;
        s_d.vld = in_valid;
        if (in_valid) s_d.res = res_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.maxv <= {NCH{ONE_PT}};
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.vld;
    assign out_r     = s_q.res[0];
    assign out_g     = s_q.res[1];
    assign out_b     = s_q.res[2];

    assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));
endmodule

// File: tb/tb_gp_palette_top.sv
`timescale 1ns/1ps
module tb_gp_palette_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_wr = 0, dat_wr = 0, mode_wr = 0, max_wr = 0;
    logic [31:0] idx_wdata = 0, dat_wdata = 0, mode_wdata = 0;
    logic [1:0]  max_sel = 0;
    logic [16:0] max_wdata = 0;
    logic        in_valid = 0, in_half = 0;
    logic [9:0]  in_r = 0, in_g = 0, in_b = 0;
    logic        out_valid;
    logic [16:0] out_r, out_g, out_b;

    int checks = 0;
    int fails  = 0;

    logic [29:0] mdl [1024];
    logic [9:0]  m_ptr = 0;
    bit          m_ai = 0, m_split = 0, m_pre = 0, m_post = 0;
    logic [1:0]  m_mode = 0;
    logic [16:0] m_max [3];

    always #2 clk = ~clk;

    gp_palette_top dut (
        .clk(clk), .rst_n(rst_n),
        .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .max_wr(max_wr), .max_sel(max_sel), .max_wdata(max_wdata),
        .in_valid(in_valid), .in_half(in_half),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_ch(input int ch, input logic [9:0] v, input bit half);
        logic [9:0] a, val;
        logic [16:0] sc;
        logic [29:0] e;
        bit act;
        act = (m_pre || m_post) && (m_mode != 2'd0);
        a = (m_mode == 2'd3) ? {half, v[9:1]} : v;
        e = mdl[a];
        val = act ? e[(2-ch)*10 +: 10] : v;
        sc = {1'b0, val, 6'b0};
        return (sc > m_max[ch]) ? m_max[ch] : sc;
    endfunction

    task automatic do_idx(input bit sp, input bit ai, input logic [9:0] p);
        idx_wdata = {sp, 15'h5a5a, ai, 5'h15, p};
        idx_wr = 1;
        @(negedge clk);
        idx_wr = 0;
        m_ptr = p; m_ai = ai; m_split = sp;
    endtask

    task automatic model_dat(input logic [29:0] e);
        mdl[m_ptr] = e;
        if (m_ai) begin
            if (m_split) m_ptr = {m_ptr[9], m_ptr[8:0] + 9'd1};
            else         m_ptr = m_ptr + 10'd1;
        end
    endtask

    task automatic do_dat(input logic [29:0] e);
        dat_wdata = {2'b11, e};
        dat_wr = 1;
        @(negedge clk);
        dat_wr = 0;
        model_dat(e);
    endtask

    task automatic do_mode(input logic [31:0] w);
        mode_wdata = w;
        mode_wr = 1;
        @(negedge clk);
        mode_wr = 0;
        m_mode = w[1:0]; m_pre = w[31]; m_post = w[30];
    endtask

    task automatic do_max(input logic [1:0] ch, input logic [16:0] v);
        max_sel = ch; max_wdata = v; max_wr = 1;
        @(negedge clk);
        max_wr = 0;
        if (ch != 2'd3) m_max[ch] = v;
    endtask

    task automatic look(input string req, input logic [9:0] r, input logic [9:0] g,
                        input logic [9:0] b, input bit half);
        logic [16:0] er, eg, eb;
        er = exp_ch(0, r, half); eg = exp_ch(1, g, half); eb = exp_ch(2, b, half);
        in_r = r; in_g = g; in_b = b; in_half = half; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
        chk({req, " red"},   {15'b0, out_r}, {15'b0, er});
        chk({req, " green"}, {15'b0, out_g}, {15'b0, eg});
        chk({req, " blue"},  {15'b0, out_b}, {15'b0, eb});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [16:0] hr, hg, hb;
        logic [29:0] e0;
        int unsigned sd;
        sd = $urandom(32'd20240611);
        for (int i = 0; i < 3; i++) m_max[i] = 17'h10000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", {31'b0, out_valid}, 0);
        chk("R1 results", {15'b0, out_r | out_g | out_b}, 0);
        rst_n = 1;
        @(negedge clk);
        // R1 and R6: default control is pass-through, ceiling 0x10000 does not limit 1023
        look("R1 pass default", 10'h155, 10'h3ff, 10'h000, 0);
        // R3 and R4: load three entries with auto-advance from 0, read them in 10-bit mode
        do_idx(0, 1, 10'd0);
        do_dat({10'h011, 10'h022, 10'h033});
        do_dat({10'h144, 10'h255, 10'h366});
        do_dat({10'h3ff, 10'h001, 10'h2aa});
        do_mode(32'h4000_0001);
        look("R3 pack entry0", 10'd0, 10'd0, 10'd0, 0);
        look("R4 advance", 10'd1, 10'd2, 10'd0, 0);
        // R4: auto-advance off overwrites the same entry
        do_idx(0, 0, 10'd5);
        do_dat({10'h100, 10'h100, 10'h100});
        do_dat({10'h0f0, 10'h0e0, 10'h0d0});
        do_idx(0, 1, 10'd6);
        do_dat({10'h001, 10'h002, 10'h003});
        look("R4 no advance", 10'd5, 10'd6, 10'd5, 0);
        // R5: full wrap 1023 -> 0
        do_idx(0, 1, 10'd1023);
        do_dat({10'h3a1, 10'h3a2, 10'h3a3});
        do_dat({10'h0b1, 10'h0b2, 10'h0b3});
        look("R5 full wrap", 10'd1023, 10'd0, 10'd1023, 0);
        // R5: half-confined wrap 511 -> 0 and 1023 -> 512
        do_idx(1, 1, 10'd511);
        do_dat({10'h051, 10'h052, 10'h053});
        do_dat({10'h061, 10'h062, 10'h063});
        do_idx(1, 1, 10'd1023);
        do_dat({10'h071, 10'h072, 10'h073});
        do_dat({10'h081, 10'h082, 10'h083});
        do_idx(0, 0, 10'd0);
        do_idx(0, 1, 10'd1);
        do_dat({10'h091, 10'h092, 10'h093});
        look("R5 half wrap low", 10'd511, 10'd0, 10'd1, 0);
        look("R5 half wrap high", 10'd1023, 10'd512, 10'd1023, 0);
        // R6: upper junk bits ignored, 12-bit code behaves as full table
        do_mode(32'h8ff0_fff2);
        look("R6 12-bit full", 10'd512, 10'd511, 10'd6, 0);
        do_mode(32'h4000_0000);
        look("R6 mode0 pass", 10'd1, 10'd2, 10'd3, 0);
        // R7: both enables clear -> pass-through even in table mode
        do_mode(32'h0000_0001);
        look("R7 enables off", 10'd5, 10'd1023, 10'd0, 0);
        // R8: split halves
        do_mode(32'hc000_0003);
        look("R8 split low", 10'd1, 10'd3, 10'd10, 0);
        look("R8 split high", 10'd1023, 10'd0, 10'd1, 1);
        // R9: ceilings per channel; select 3 writes nothing
        do_mode(32'h0000_0000);
        do_max(2'd0, 17'h01000);
        do_max(2'd3, 17'h00010);
        look("R9 ceiling red", 10'h3ff, 10'h3ff, 10'h010, 0);
        do_max(2'd2, 17'h00400);
        look("R9 ceiling blue", 10'h020, 10'h001, 10'h3ff, 0);
        do_max(2'd0, 17'h10000);
        do_max(2'd2, 17'h10000);
        // R10: no request -> valid low, results held
        hr = out_r; hg = out_g; hb = out_b;
        in_r = 10'h3ff; in_g = 10'h123; in_b = 10'h321;
        @(negedge clk);
        chk("R10 valid low", {31'b0, out_valid}, 0);
        chk("R10 hold", {15'b0, out_r ^ out_g ^ out_b}, {15'b0, hr ^ hg ^ hb});
        // R11: same-cycle write and read of entry 2 returns old value
        do_mode(32'h4000_0001);
        do_idx(0, 0, 10'd2);
        e0 = 30'h1555_5555;
        hr = exp_ch(0, 10'd2, 0); hg = exp_ch(1, 10'd2, 0); hb = exp_ch(2, 10'd2, 0);
        dat_wdata = {2'b0, e0}; dat_wr = 1;
        in_r = 10'd2; in_g = 10'd2; in_b = 10'd2; in_valid = 1;
        @(negedge clk);
        dat_wr = 0; in_valid = 0;
        model_dat(e0);
        chk("R11 old red", {15'b0, out_r}, {15'b0, hr});
        chk("R11 old green", {15'b0, out_g}, {15'b0, hg});
        chk("R11 old blue", {15'b0, out_b}, {15'b0, hb});
        look("R11 new value", 10'd2, 10'd2, 10'd2, 0);
        // random phase: fill whole table, then mixed lookups (R3 R6 R8 R9)
        do_idx(0, 1, 10'd0);
        for (int i = 0; i < 1024; i++) do_dat(30'($urandom));
        for (int i = 0; i < 500; i++) begin
            if (($urandom % 8) == 0)
                do_mode({2'($urandom), 28'($urandom), 2'($urandom)});
            if (($urandom % 10) == 0)
                do_max(2'($urandom), 17'($urandom % 32'h14000));
            look("R8 random", 10'($urandom), 10'($urandom), 10'($urandom), 1'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule